// File: doc/BRIEF.md
# Sigma-Delta Converter Setup and Sample Sequencer

This block drives a multi-channel sigma-delta converter through the request/response port of a separate register-access engine. The engine handles the serial signalling and the framing checksum. After a start pulse the sequencer first sends a reset command and reads the identity word. It then turns on checksum protection for register traffic and opens itself for channel configuration. From then on it polls the status byte at a fixed interval. Each completed conversion is returned as a sign-relocated 32-bit word, together with the channel that produced it.

A configuration request names a slot, plus a positive and a negative input selector. The sequencer applies it to three converter registers: setup, filter and channel. For each one it reads the whole register, changes only its own fields, and writes the whole register back. Every request is held stable on the engine port until the engine answers. A checksum fault reported by the engine abandons the step in progress and raises a one-cycle flag.

Top module: `sdadc_cfg_seq`

## Requirements
- R1: While reset is held and after it is released, req_valid, boot_done, cfg_ready, smp_valid, id_warn and chk_err are all 0.
- R2: After start, exactly four requests are issued, in this order: a reset command (req_reset=1), a 2-byte read of address 0x07, a 2-byte read of address 0x02, and a 2-byte write of address 0x02. boot_done rises after the write is answered and stays high. Each request is held until answered.
- R3: id_warn is 1 when the identity word read from 0x07 gives (id & 0xFFF0) != 0x00D0, and 0 otherwise. Boot completes in both cases.
- R4: In 2-byte registers, rdata/wdata[15:8] hold the first byte and [7:0] the second. The write to 0x02 carries the value just read, with bits [3:2] forced to 2'b10 and all other bits kept. req_crc_on is 0 on every boot request before that write, and 1 on that write and on every later request.
- R5: cfg_ready is 0 until boot has finished and while any request is outstanding. A request accepted with cfg_valid and cfg_ready produces six requests, in this order: read and write of 0x20+n, read and write of 0x28+n, read and write of 0x10+n. Each read and write is 2 bytes, and n is the slot.
- R6: The setup write (0x20+n) equals the value read, with bit 12 cleared, bits [11:8] set and bits [5:4] cleared.
- R7: The filter write (0x28+n) equals the value read, with bits [11:8] set to 4'b1110 and bits [6:5] cleared.
- R8: The channel write (0x10+n) equals the value read, with bit 15 set, bits [13:12] = n, bits [9:8] = positive selector [4:3], bits [7:5] = positive selector [2:0] and bits [4:0] = negative selector. Bits 14, 11 and 10 are kept.
- R9: With no configuration pending, a 1-byte status read of 0x00 is issued no sooner than POLL_GAP cycles after the previous request is answered. If status bit 7 is 1, no data read and no sample follow.
- R10: If status bit 7 is 0, a 3-byte read of 0x04 follows. One cycle after its error-free response, smp_valid pulses for one cycle and smp_chan equals status bits [1:0].
- R11: smp_data is the 24-bit result zero-extended when its bit 23 is 0. When bit 23 is 1, smp_data is {1'b1, 8'b0, result[22:0]}.
- R12: A response with rsp_chk_err set abandons the current step and pulses chk_err one cycle later. No sample is produced for that response. The sequencer returns to polling, or to idle if boot has not finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the boot sequence (taken in idle) |
| cfg_valid | input | 1 | Configuration request present |
| cfg_ready | output | 1 | Configuration request may be taken this cycle |
| cfg_slot | input | 2 | Channel/setup slot n |
| cfg_pos | input | 5 | Positive input selector |
| cfg_neg | input | 5 | Negative input selector |
| req_valid | output | 1 | Request to the register engine, held until answered |
| req_reset | output | 1 | Request is a converter reset command |
| req_write | output | 1 | Request is a register write |
| req_addr | output | 8 | Register address |
| req_len | output | 2 | Register length in bytes |
| req_wdata | output | 24 | Write data, right-aligned |
| req_crc_on | output | 1 | Checksum mode used for this request |
| rsp_valid | input | 1 | Engine response strobe |
| rsp_rdata | input | 24 | Read data, right-aligned |
| rsp_chk_err | input | 1 | Engine saw a checksum mismatch |
| boot_done | output | 1 | Boot sequence finished |
| id_warn | output | 1 | Identity word did not match |
| chk_err | output | 1 | One-cycle pulse on an aborted step |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_chan | output | 2 | Channel of the sample |
| smp_data | output | 32 | Sign-relocated sample |

## Verification
All outputs come from registers or from the registered state, so request fields are visible from the cycle after the state changes. smp_valid, smp_data and chk_err follow the response by exactly one clock edge. The bench's engine model answers on falling edges after a random delay, logs every request at the moment it answers it, and samples the sequencer's outputs on the next falling edge. Polling gaps are measured between consecutive status answers and compared with a lower bound. They are never compared for exact equality, so the random engine latency cannot break the check.

// File: rtl/sdadc_seq_pkg.sv
package sdadc_seq_pkg;
  localparam int SEL_W  = 5;
  localparam int SLOT_W = 2;
  localparam int ADDR_W = 8;
  localparam int RAW_W  = 24;
  localparam int SMP_W  = 32;
  localparam int REG_W  = 16;

  localparam logic [ADDR_W-1:0] A_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] A_IFACE  = 8'h02;
  localparam logic [ADDR_W-1:0] A_RESULT = 8'h04;
  localparam logic [ADDR_W-1:0] A_IDENT  = 8'h07;
  localparam logic [ADDR_W-1:0] A_CHAN   = 8'h10;
  localparam logic [ADDR_W-1:0] A_SETUP  = 8'h20;
  localparam logic [ADDR_W-1:0] A_FILT   = 8'h28;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_ID, S_IFR, S_IFW, S_WAIT, S_STAT, S_DATA,
    S_SUR, S_SUW, S_FLR, S_FLW, S_CHR, S_CHW
  } seq_state_e;

  typedef enum logic [1:0] {ED_IFACE, ED_SETUP, ED_FILT, ED_CHAN} edit_kind_e;
endpackage

// File: rtl/sdadc_field_edit.sv
module sdadc_field_edit
  import sdadc_seq_pkg::*;
(
  input  edit_kind_e        kind,
  input  logic [REG_W-1:0]  rd_val,
  input  logic [SLOT_W-1:0] slot,
  input  logic [SEL_W-1:0]  pos_sel,
  input  logic [SEL_W-1:0]  neg_sel,
  output logic [REG_W-1:0]  wr_val
);
  always_comb begin
    wr_val = rd_val;
    case (kind)
      ED_IFACE: wr_val[3:2] = 2'b10;
      ED_SETUP: begin
        wr_val[12]   = 1'b0;
        wr_val[11:8] = 4'hF;
        wr_val[5:4]  = 2'b00;
      end
      ED_FILT: begin
        wr_val[11]   = 1'b1;
        wr_val[10:8] = 3'b110;
        wr_val[6:5]  = 2'b00;
      end
      default: begin
        wr_val[15]    = 1'b1;
        wr_val[13:12] = slot;
        wr_val[9:8]   = pos_sel[4:3];
        wr_val[7:5]   = pos_sel[2:0];
        wr_val[4:0]   = neg_sel;
      end
    endcase
  end
endmodule

// File: rtl/sdadc_sample_map.sv
module sdadc_sample_map #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] mapped
);
  localparam int PAD_W = OUT_W - IN_W;
  always_comb begin
    if (raw[IN_W-1]) mapped = {1'b1, {PAD_W{1'b0}}, raw[IN_W-2:0]};
    else             mapped = {{PAD_W{1'b0}}, raw};
  end
endmodule

// File: rtl/sdadc_poll_timer.sv
module sdadc_poll_timer #(
  parameter int GAP = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(GAP + 1);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? CNT_W'(GAP) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdadc_cfg_seq.sv
module sdadc_cfg_seq
  import sdadc_seq_pkg::*;
#(
  parameter int POLL_GAP = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic [SEL_W-1:0]   cfg_pos,
  input  logic [SEL_W-1:0]   cfg_neg,
  output logic               req_valid,
  output logic               req_reset,
  output logic               req_write,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [1:0]         req_len,
  output logic [RAW_W-1:0]   req_wdata,
  output logic               req_crc_on,
  input  logic               rsp_valid,
  input  logic [RAW_W-1:0]   rsp_rdata,
  input  logic               rsp_chk_err,
  output logic               boot_done,
  output logic               id_warn,
  output logic               chk_err,
  output logic               smp_valid,
  output logic [SLOT_W-1:0]  smp_chan,
  output logic [SMP_W-1:0]   smp_data
);
  logic rs0_q, rs1_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rs0_q <= 1'b0; rs1_q <= 1'b0; end
    else        begin rs0_q <= 1'b1; rs1_q <= rs0_q; end
  end
  assign rst_i_n = rs1_q;

  seq_state_e        st_q, st_d;
  logic [REG_W-1:0]  rd_q;
  logic [SLOT_W-1:0] slot_q, chan_q;
  logic [SEL_W-1:0]  pos_q, neg_q;
  logic crc_q, boot_q, warn_q, err_q, smp_v_q;
  logic [SMP_W-1:0]  smp_q;
  logic rsp_ok, rsp_bad, tmr_load, tmr_exp, take_cfg, is_read_rmw;
  edit_kind_e        kind;
  logic [REG_W-1:0]  edit_val;
  logic [SMP_W-1:0]  mapped;

  assign rsp_ok   = rsp_valid & ~rsp_chk_err;
  assign rsp_bad  = rsp_valid &  rsp_chk_err;
  assign take_cfg = (st_q == S_WAIT) & cfg_valid;
  assign is_read_rmw = (st_q == S_IFR) | (st_q == S_SUR) | (st_q == S_FLR) | (st_q == S_CHR);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (start) st_d = S_RST;
      S_RST:  if (rsp_ok) st_d = S_ID;
      S_ID:   if (rsp_ok) st_d = S_IFR;
      S_IFR:  if (rsp_ok) st_d = S_IFW;
      S_IFW:  if (rsp_ok) st_d = S_WAIT;
      S_WAIT: if (cfg_valid) st_d = S_SUR;
              else if (tmr_exp) st_d = S_STAT;
      S_STAT: if (rsp_ok) st_d = rsp_rdata[7] ? S_WAIT : S_DATA;
      S_DATA: if (rsp_ok) st_d = S_WAIT;
      S_SUR:  if (rsp_ok) st_d = S_SUW;
      S_SUW:  if (rsp_ok) st_d = S_FLR;
      S_FLR:  if (rsp_ok) st_d = S_FLW;
      S_FLW:  if (rsp_ok) st_d = S_CHR;
      S_CHR:  if (rsp_ok) st_d = S_CHW;
      S_CHW:  if (rsp_ok) st_d = S_WAIT;
      default: st_d = S_IDLE;
    endcase
    if (rsp_bad && st_q != S_IDLE && st_q != S_WAIT) st_d = boot_q ? S_WAIT : S_IDLE;
    tmr_load = (st_d == S_WAIT) && (st_q != S_WAIT);
  end

  always_comb begin
    req_valid = (st_q != S_IDLE) && (st_q != S_WAIT);
    req_reset = (st_q == S_RST);
    req_write = (st_q == S_IFW) | (st_q == S_SUW) | (st_q == S_FLW) | (st_q == S_CHW);
    req_crc_on = crc_q | (st_q == S_IFW);
    req_len  = 2'd2;
    req_addr = A_STATUS;
    kind     = ED_CHAN;
    case (st_q)
      S_RST:         req_len = 2'd0;
      S_ID:          req_addr = A_IDENT;
      S_IFR, S_IFW: begin req_addr = A_IFACE; kind = ED_IFACE; end
      S_STAT:        req_len = 2'd1;
      S_DATA: begin  req_addr = A_RESULT; req_len = 2'd3; end
      S_SUR, S_SUW: begin req_addr = A_SETUP | ADDR_W'(slot_q); kind = ED_SETUP; end
      S_FLR, S_FLW: begin req_addr = A_FILT | ADDR_W'(slot_q); kind = ED_FILT; end
      S_CHR, S_CHW:  req_addr = A_CHAN | ADDR_W'(slot_q);
      default: ;
    endcase
    req_wdata = {{(RAW_W-REG_W){1'b0}}, edit_val};
  end

  sdadc_field_edit edit_i (
    .kind(kind), .rd_val(rd_q), .slot(slot_q),
    .pos_sel(pos_q), .neg_sel(neg_q), .wr_val(edit_val)
  );

  sdadc_sample_map #(.IN_W(RAW_W), .OUT_W(SMP_W)) map_i (
    .raw(rsp_rdata), .mapped(mapped)
  );

  sdadc_poll_timer #(.GAP(POLL_GAP)) tmr_i (
    .clk(clk), .rst_n(rst_i_n), .load(tmr_load),
    .run(st_q == S_WAIT), .expired(tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q <= S_IDLE;
      crc_q <= 1'b0; boot_q <= 1'b0; warn_q <= 1'b0;
      err_q <= 1'b0; smp_v_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      err_q   <= rsp_bad && (st_q != S_IDLE) && (st_q != S_WAIT);
      smp_v_q <= rsp_ok && (st_q == S_DATA);
      if (st_q == S_IDLE && start) begin
        crc_q <= 1'b0; boot_q <= 1'b0; warn_q <= 1'b0;
      end
      if (rsp_ok && st_q == S_ID) warn_q <= (rsp_rdata[15:4] != 12'h00D);
      if (rsp_ok && st_q == S_IFW) begin crc_q <= 1'b1; boot_q <= 1'b1; end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_ok && is_read_rmw) rd_q <= rsp_rdata[REG_W-1:0];
    if (take_cfg) begin slot_q <= cfg_slot; pos_q <= cfg_pos; neg_q <= cfg_neg; end
    if (rsp_ok && st_q == S_STAT) chan_q <= rsp_rdata[SLOT_W-1:0];
    if (rsp_ok && st_q == S_DATA) smp_q <= mapped;
  end

  assign cfg_ready = (st_q == S_WAIT);
  assign boot_done = boot_q;
  assign id_warn   = warn_q;
  assign chk_err   = err_q;
  assign smp_valid = smp_v_q;
  assign smp_chan  = chan_q;
  assign smp_data  = smp_q;
endmodule

// File: rtl/sdadc_cfg_seq_chk.sv
module sdadc_cfg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_ready,
  input logic       req_valid,
  input logic       req_write,
  input logic [7:0] req_addr,
  input logic       req_crc_on,
  input logic       rsp_valid,
  input logic       rsp_chk_err,
  input logic       boot_done,
  input logic       smp_valid
);
  p_boot_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> !cfg_ready);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid) |=> (req_valid && $stable(req_addr) && $stable(req_write)));
  p_boot_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);
  p_crc_after_boot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && req_valid) |-> req_crc_on);
  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  p_err_no_sample_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_chk_err) |=> !smp_valid);
endmodule

bind sdadc_cfg_seq sdadc_cfg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_ready(cfg_ready), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .req_crc_on(req_crc_on),
  .rsp_valid(rsp_valid), .rsp_chk_err(rsp_chk_err), .boot_done(boot_done),
  .smp_valid(smp_valid)
);

// File: tb/sdadc_cfg_seq_tb.sv
module sdadc_cfg_seq_tb_top;
  localparam int GAP = 16;
  localparam int LOGN = 2048;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic cfg_valid = 1'b0, cfg_ready;
  logic [1:0] cfg_slot = '0;
  logic [4:0] cfg_pos = '0, cfg_neg = '0;
  logic req_valid, req_reset, req_write, req_crc_on;
  logic [7:0] req_addr;
  logic [1:0] req_len;
  logic [23:0] req_wdata;
  logic rsp_valid = 1'b0, rsp_chk_err = 1'b0;
  logic [23:0] rsp_rdata = '0;
  logic boot_done, id_warn, chk_err, smp_valid;
  logic [1:0] smp_chan;
  logic [31:0] smp_data;

  always #5 clk = ~clk;

  sdadc_cfg_seq #(.POLL_GAP(GAP)) dut_i (.*);

  int checks = 0, fails = 0, cyc = 0;
  logic [23:0] mem [0:63];
  int lg_n = 0, lat = 0;
  logic [7:0] lg_addr [0:LOGN-1];
  logic [23:0] lg_wd [0:LOGN-1];
  logic [1:0] lg_len [0:LOGN-1];
  logic lg_wr [0:LOGN-1], lg_rst [0:LOGN-1], lg_crc [0:LOGN-1];
  bit err_arm = 0; logic [7:0] err_addr = 8'hFF;
  int last_stat = -1; bit last_notready = 0; int gap_bad = 0, stat_n = 0, data_bad = 0;
  int smp_cnt = 0, err_cnt = 0, early_cfg = 0;
  logic [31:0] last_data; logic [1:0] last_chan;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] e_iface(logic [15:0] v); return (v & ~16'h000C) | 16'h0008; endfunction
  function automatic logic [15:0] e_setup(logic [15:0] v); return (v & ~16'h1F30) | 16'h0F00; endfunction
  function automatic logic [15:0] e_filt(logic [15:0] v);  return (v & ~16'h0F60) | 16'h0E00; endfunction
  function automatic logic [15:0] e_chan(logic [15:0] v, logic [1:0] n, logic [4:0] p, logic [4:0] q);
    return (v & 16'h4C00) | 16'h8000 | {2'b0, n, 12'h0} | {6'b0, p[4:3], 8'h0} | {8'h0, p[2:0], 5'h0} | {11'h0, q};
  endfunction
  function automatic logic [31:0] e_map(logic [23:0] d);
    return d[23] ? {1'b1, 8'h00, d[22:0]} : {8'h00, d};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // engine model and monitors
  always @(negedge clk) begin
    if (smp_valid) begin smp_cnt++; last_data = smp_data; last_chan = smp_chan; end
    if (chk_err) err_cnt++;
    if (cfg_ready && !boot_done) early_cfg++;
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_chk_err <= 1'b0; lat = 0;
    end else if (rsp_valid) begin
      rsp_valid <= 1'b0; rsp_chk_err <= 1'b0; lat = $urandom % 3;
    end else if (req_valid) begin
      if (lat != 0) lat--;
      else begin
        automatic bit e = err_arm && (req_addr == err_addr);
        automatic int a = req_addr[5:0];
        if (e) err_arm = 0;
        if (lg_n < LOGN) begin
          lg_addr[lg_n] = req_addr; lg_wd[lg_n] = req_wdata; lg_len[lg_n] = req_len;
          lg_wr[lg_n] = req_write; lg_rst[lg_n] = req_reset; lg_crc[lg_n] = req_crc_on;
          lg_n++;
        end
        rsp_rdata <= req_write ? 24'h0 : mem[a];
        rsp_chk_err <= e;
        rsp_valid <= 1'b1;
        if (!req_reset && req_addr == 8'h00) begin
          if (last_stat >= 0 && last_notready && (cyc - last_stat) <= GAP) gap_bad++;
          last_stat = cyc; last_notready = mem[0][7]; stat_n++;
        end
        if (!req_reset && req_addr == 8'h04) begin
          if (last_notready) data_bad++;
          if (!e) mem[0] = 24'h80;
        end
        if (req_write && !e) mem[a] = req_wdata;
      end
    end
  end

  task automatic chk_req(int i, bit rst, bit wr, logic [7:0] addr, logic [1:0] len, bit crc, string req);
    check(lg_rst[i] == rst && lg_wr[i] == wr && (rst || (lg_addr[i] == addr && lg_len[i] == len)) && lg_crc[i] == crc,
          req, {lg_rst[i], lg_wr[i], lg_crc[i], 3'b0, lg_len[i], lg_addr[i]}, {rst, wr, crc, 3'b0, len, addr});
  endtask

  task automatic wait_log(int target);
    int t = 0;
    while (lg_n < target && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic boot(logic [15:0] id, bit exp_warn);
    int b;
    logic [15:0] ifv;
    rst_n = 1'b0; start = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = 24'($urandom & 16'hFFFF);
    mem[0] = 24'h80; mem[7] = {8'h0, id}; ifv = mem[2][15:0];
    repeat (3) @(negedge clk);
    check(!req_valid && !boot_done && !cfg_ready && !smp_valid && !id_warn && !chk_err, "R1 in reset",
          {26'b0, req_valid, boot_done, cfg_ready, smp_valid, id_warn, chk_err}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!req_valid && !boot_done && !cfg_ready && !smp_valid, "R1 after release",
          {28'b0, req_valid, boot_done, cfg_ready, smp_valid}, 32'h0);
    b = lg_n;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_log(b + 4);
    repeat (3) @(negedge clk);
    chk_req(b, 1, 0, 8'h00, 2'd0, 0, "R2 reset command first");
    chk_req(b + 1, 0, 0, 8'h07, 2'd2, 0, "R2 identity read");
    chk_req(b + 2, 0, 0, 8'h02, 2'd2, 0, "R4 iface read checksum off");
    chk_req(b + 3, 0, 1, 8'h02, 2'd2, 1, "R4 iface write checksum on");
    check(lg_wd[b + 3][15:0] == e_iface(ifv), "R4 iface bits", {16'b0, lg_wd[b + 3][15:0]}, {16'b0, e_iface(ifv)});
    check(boot_done == 1'b1, "R2 boot_done", {31'b0, boot_done}, 32'h1);
    check(id_warn == exp_warn, "R3 id_warn", {31'b0, id_warn}, {31'b0, exp_warn});
  endtask

  task automatic do_cfg(logic [1:0] n, logic [4:0] p, logic [4:0] q);
    logic [15:0] su, fl, ch;
    int b, t;
    su = 16'($urandom); fl = 16'($urandom); ch = 16'($urandom);
    mem[8'h20 + n] = {8'h0, su}; mem[8'h28 + n] = {8'h0, fl}; mem[8'h10 + n] = {8'h0, ch};
    t = 0;
    while (!cfg_ready && t < 1000) begin @(negedge clk); t++; end
    b = lg_n;
    cfg_valid = 1'b1; cfg_slot = n; cfg_pos = p; cfg_neg = q;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_slot = $urandom; cfg_pos = $urandom; cfg_neg = $urandom;
    wait_log(b + 6);
    chk_req(b,     0, 0, 8'h20 + n, 2'd2, 1, "R5 setup read");
    chk_req(b + 1, 0, 1, 8'h20 + n, 2'd2, 1, "R5 setup write");
    chk_req(b + 2, 0, 0, 8'h28 + n, 2'd2, 1, "R5 filter read");
    chk_req(b + 3, 0, 1, 8'h28 + n, 2'd2, 1, "R5 filter write");
    chk_req(b + 4, 0, 0, 8'h10 + n, 2'd2, 1, "R5 channel read");
    chk_req(b + 5, 0, 1, 8'h10 + n, 2'd2, 1, "R5 channel write");
    check(lg_wd[b + 1][15:0] == e_setup(su), "R6 setup fields", {16'b0, lg_wd[b + 1][15:0]}, {16'b0, e_setup(su)});
    check(lg_wd[b + 3][15:0] == e_filt(fl), "R7 filter fields", {16'b0, lg_wd[b + 3][15:0]}, {16'b0, e_filt(fl)});
    check(lg_wd[b + 5][15:0] == e_chan(ch, n, p, q), "R8 channel fields",
          {16'b0, lg_wd[b + 5][15:0]}, {16'b0, e_chan(ch, n, p, q)});
  endtask

  task automatic do_sample(logic [23:0] d, logic [1:0] c);
    int b = smp_cnt, t = 0;
    mem[4] = d; mem[0] = {16'h0, 6'h0, c};
    while (smp_cnt == b && t < 2000) begin @(negedge clk); t++; end
    check(smp_cnt == b + 1, "R10 sample strobe", smp_cnt, b + 1);
    check(last_chan == c, "R10 sample channel", {30'b0, last_chan}, {30'b0, c});
    check(last_data == e_map(d), "R11 sample mapping", last_data, e_map(d));
  endtask

  initial begin
    int s0;
    void'($urandom(32'd1234));
    boot(16'h00D5, 1'b0);
    repeat (120) @(negedge clk);
    check(smp_cnt == 0, "R9 no sample while not ready", smp_cnt, 0);
    do_cfg(2'd0, 5'd1, 5'd0);
    do_cfg(2'd3, 5'd31, 5'd22);
    for (int k = 0; k < 4; k++) do_cfg(2'($urandom), 5'($urandom), 5'($urandom));
    do_sample(24'h800001, 2'd1);
    do_sample(24'h7FFFFF, 2'd2);
    do_sample(24'hFFFFFF, 2'd3);
    do_sample(24'h000000, 2'd0);
    for (int k = 0; k < 5; k++) do_sample(24'($urandom), 2'($urandom));
    // checksum fault on the data read
    begin
      int be = err_cnt, t = 0;
      s0 = smp_cnt;
      err_addr = 8'h04; err_arm = 1;
      mem[4] = 24'h812345; mem[0] = 24'h2;
      while (err_cnt == be && t < 2000) begin @(negedge clk); t++; end
      check(err_cnt == be + 1, "R12 chk_err pulse", err_cnt, be + 1);
      @(negedge clk);
      check(smp_cnt == s0, "R12 no sample on fault", smp_cnt, s0);
      t = 0;
      while (smp_cnt == s0 && t < 2000) begin @(negedge clk); t++; end
      check(last_data == e_map(24'h812345), "R12 recovery sample", last_data, e_map(24'h812345));
    end
    repeat (100) @(negedge clk);
    check(gap_bad == 0 && stat_n > 5, "R9 poll spacing", gap_bad, 0);
    check(data_bad == 0, "R9 no data read after not-ready", data_bad, 0);
    check(early_cfg == 0, "R5 cfg_ready during boot", early_cfg, 0);
    boot(16'h1234, 1'b1);
    check(early_cfg == 0, "R5 cfg_ready during second boot", early_cfg, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule